// File: doc/BRIEF.md
# Descriptor DMA Channel Control/Status Register

This block holds the control and status state of one descriptor-driven DMA channel and the register-access rules in front of it. Software writes the control word on a 32-bit register bus. Each write carries a per-bit mask and a value, so one write can set or clear any subset of the software-owned channel bits without a read-modify-write. The block works out whether the channel is active. It pulses a flush request to the attached device and a kick to the descriptor sequencer.

The block also guards the command-pointer register. Writes to it are dropped while the channel is active. An accepted write is forced to 16-byte alignment and requests a descriptor fetch. A few plain selector registers fill out the rest of the channel's register window. The sequencer is a separate block. It reports dead, branch-taken, stop and fetch events through single-cycle inputs, and it reads the channel state from a status output.

Top module: `dma_chan_csr`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, the status word is zero, and `flush_req`, `kick` and `fetch_req` are low.
- R2: A write to word 0 treats bits 31:16 as a per-bit mask and bits 15:0 as values. A status bit whose mask bit is zero keeps its value. Reads of word 0 return the status word: RUN bit 15, PAUSE 14, FLUSH 13, WAKE 12, DEAD 11, ACTIVE 10, BT 8, and the device status input in bits 3:0.
- R3: A masked RUN=1 sets RUN. A masked RUN=0 clears both RUN and DEAD and raises `flush_req` for the cycle after the write.
- R4: A masked WAKE=1 sets WAKE only if RUN is set once that same write has been applied. Otherwise WAKE is unchanged.
- R5: A masked PAUSE write copies the PAUSE value into status.
- R6: After a control write, ACTIVE is 0 if PAUSE is 1 or RUN is 0. Otherwise ACTIVE becomes 1 if the write masked RUN or PAUSE, or set WAKE. In every other case ACTIVE keeps its value.
- R7: A masked FLUSH=1 raises `flush_req` and makes FLUSH read as 1 for exactly the one cycle after the write. FLUSH then reads 0.
- R8: A write to word 1 (command pointer) is ignored while ACTIVE is 1. Otherwise the pointer stores the data with bits 3:0 forced to zero, and `fetch_req` pulses for one cycle.
- R9: Software cannot write DEAD, ACTIVE or BT. `seq_dead` sets DEAD and clears ACTIVE. `seq_stop` clears ACTIVE. `seq_bt_set` and `seq_bt_clr` set and clear BT. `seq_wake_clr` clears WAKE.
- R10: `kick` pulses in the cycle after every control write that leaves ACTIVE at 1.
- R11: Words 2 to NUM_REGS-1 are plain 32-bit registers that read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | IDX_W | Word index of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_idx` (combinational) |
| dev_stat | input | 4 | Device condition bits shown in status 3:0 |
| seq_dead | input | 1 | Sequencer: channel died |
| seq_stop | input | 1 | Sequencer: stop descriptor executed |
| seq_bt_set | input | 1 | Sequencer: branch taken |
| seq_bt_clr | input | 1 | Sequencer: sequential advance |
| seq_wake_clr | input | 1 | Sequencer: descriptor fetched |
| chan_status | output | 16 | Live status word |
| cmd_ptr | output | 32 | Command pointer |
| flush_req | output | 1 | One-cycle device flush request |
| kick | output | 1 | One-cycle sequencer kick |
| fetch_req | output | 1 | One-cycle descriptor fetch request |

## Verification
A wrong next-state decision in the control logic shows up at the status read port on the very next cycle. Typical cases are ACTIVE staying high while paused, WAKE set on a stopped channel, or a hardware-only bit taking a software value. A wrong pulse shows as `kick`, `flush_req` or `fetch_req` missing or present in the cycle right after the write. A broken command-pointer guard shows as a changed pointer value on the next read. A FLUSH bit held too long is caught because the bench samples status in both the cycle after the write and the cycle after that.

// File: rtl/dma_csr_pkg.sv
// Shared constants for the DMA channel control/status register block.
// Assumes a 16-bit status word in the lower half of a 32-bit register.
package dma_csr_pkg;
    localparam int ST_W       = 16;
    localparam int B_RUN      = 15;
    localparam int B_PAUSE    = 14;
    localparam int B_FLUSH    = 13;
    localparam int B_WAKE     = 12;
    localparam int B_DEAD     = 11;
    localparam int B_ACTIVE   = 10;
    localparam int B_BT       = 8;
    localparam int IDX_CTL    = 0;
    localparam int IDX_CMDPTR = 1;
    localparam int FIRST_SCR  = 2;
endpackage

// File: rtl/dma_csr_ctl.sv
// Control/status state: applies masked control writes, derives ACTIVE,
// takes sequencer events, and emits flush and kick pulses.
// Assumes sequencer events are applied after a same-cycle control write.
module dma_csr_ctl
    import dma_csr_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctl_wr,
    input  logic [31:0]     wdata,
    input  logic [3:0]      dev_stat,
    input  logic            seq_dead,
    input  logic            seq_stop,
    input  logic            seq_bt_set,
    input  logic            seq_bt_clr,
    input  logic            seq_wake_clr,
    output logic [ST_W-1:0] status,
    output logic            flush_req,
    output logic            kick
);
    logic [ST_W-1:4] st_q, st_d;
    logic            do_flush;
    logic [15:0]     msk, val;

    assign msk = wdata[31:16];
    assign val = wdata[15:0];

    // Next status from the control write followed by sequencer events.
    always_comb begin
        st_d          = st_q;
        st_d[B_FLUSH] = 1'b0;
        do_flush      = 1'b0;
        if (ctl_wr) begin
            if (msk[B_RUN] && val[B_RUN]) st_d[B_RUN] = 1'b1;
            if (msk[B_RUN] && !val[B_RUN]) begin
                st_d[B_RUN]  = 1'b0;
                st_d[B_DEAD] = 1'b0;
                do_flush     = 1'b1;
            end
            if (msk[B_WAKE] && val[B_WAKE] && st_d[B_RUN]) st_d[B_WAKE] = 1'b1;
            if (msk[B_PAUSE]) st_d[B_PAUSE] = val[B_PAUSE];
            if (msk[B_FLUSH] && val[B_FLUSH]) begin
                st_d[B_FLUSH] = 1'b1;
                do_flush      = 1'b1;
            end
            if (st_d[B_PAUSE] || !st_d[B_RUN])
                st_d[B_ACTIVE] = 1'b0;
            else if (msk[B_RUN] || msk[B_PAUSE])
                st_d[B_ACTIVE] = 1'b1;
            else if (msk[B_WAKE] && val[B_WAKE])
                st_d[B_ACTIVE] = 1'b1;
        end
        if (seq_dead) begin
            st_d[B_DEAD]   = 1'b1;
            st_d[B_ACTIVE] = 1'b0;
        end
        if (seq_stop)     st_d[B_ACTIVE] = 1'b0;
        if (seq_bt_set)   st_d[B_BT]     = 1'b1;
        if (seq_bt_clr)   st_d[B_BT]     = 1'b0;
        if (seq_wake_clr) st_d[B_WAKE]   = 1'b0;
    end

    // Status register and one-cycle output pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            flush_req <= 1'b0;
            kick      <= 1'b0;
        end else begin
            st_q      <= st_d;
            flush_req <= do_flush;
            kick      <= ctl_wr && st_d[B_ACTIVE];
        end
    end

    assign status = {st_q, dev_stat};

    a_r6_active_needs_run_unpaused: assert property (@(posedge clk) disable iff (!rst_n)
        st_q[B_ACTIVE] |-> (st_q[B_RUN] && !st_q[B_PAUSE]));
    a_r4_wake_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q[B_WAKE]) |-> st_q[B_RUN]);
    a_r3_run_drop_flushes: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q[B_RUN]) |-> flush_req);
    a_r7_flush_bit_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        st_q[B_FLUSH] |-> flush_req);
    a_r10_kick_means_active: assert property (@(posedge clk) disable iff (!rst_n)
        kick |-> (st_q[B_ACTIVE] || $past(seq_dead || seq_stop) == 1'b0 ? st_q[B_ACTIVE] : 1'b1));
endmodule

// File: rtl/dma_csr_cmdptr.sv
// Command-pointer register: drops writes while the channel is active,
// aligns accepted values to 16 bytes and pulses a fetch request.
module dma_csr_cmdptr #(
    parameter int DATA_W  = 32,
    parameter int ALIGN_B = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ptr_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              active,
    output logic [DATA_W-1:0] ptr,
    output logic              fetch_req
);
    localparam logic [DATA_W-1:0] ALIGN_MASK = ~((DATA_W'(1) << ALIGN_B) - DATA_W'(1));

    // Guarded, aligned pointer update and fetch pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr       <= '0;
            fetch_req <= 1'b0;
        end else begin
            fetch_req <= ptr_wr && !active;
            if (ptr_wr && !active) ptr <= wdata & ALIGN_MASK;
        end
    end

    a_r8_ptr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        ptr[ALIGN_B-1:0] == '0);
    a_r8_guard_while_active: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_wr && active) |=> ($stable(ptr) && !fetch_req));
endmodule

// File: rtl/dma_csr_scratch.sv
// Plain selector registers occupying word indices FIRST..NUM_REGS-1.
// Assumes NUM_REGS > FIRST; returns zero for lower indices.
module dma_csr_scratch #(
    parameter int NUM_REGS = 8,
    parameter int FIRST    = 2,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] regs [FIRST:NUM_REGS-1];

    for (genvar g = FIRST; g < NUM_REGS; g++) begin : g_reg
        // One storage word per selector register.
        always_ff @(posedge clk) begin
            if (!rst_n)                          regs[g] <= '0;
            else if (wr && idx == IDX_W'(g))     regs[g] <= wdata;
        end
    end

    // Read selection.
    always_comb begin
        rdata = '0;
        for (int i = FIRST; i < NUM_REGS; i++)
            if (idx == IDX_W'(i)) rdata = regs[i];
    end
endmodule

// File: rtl/dma_chan_csr.sv
// Top: one DMA channel's control/status and register window.
// Word 0 writes control / reads status, word 1 is the command pointer,
// remaining words are plain registers. Reads are combinational.
module dma_chan_csr
    import dma_csr_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [3:0]        dev_stat,
    input  logic              seq_dead,
    input  logic              seq_stop,
    input  logic              seq_bt_set,
    input  logic              seq_bt_clr,
    input  logic              seq_wake_clr,
    output logic [ST_W-1:0]   chan_status,
    output logic [DATA_W-1:0] cmd_ptr,
    output logic              flush_req,
    output logic              kick,
    output logic              fetch_req
);
    logic              ctl_wr, ptr_wr;
    logic [DATA_W-1:0] scr_rdata;

    assign ctl_wr = reg_wr && reg_idx == IDX_W'(IDX_CTL);
    assign ptr_wr = reg_wr && reg_idx == IDX_W'(IDX_CMDPTR);

    dma_csr_ctl u_ctl (
        .clk, .rst_n, .ctl_wr, .wdata(reg_wdata), .dev_stat,
        .seq_dead, .seq_stop, .seq_bt_set, .seq_bt_clr, .seq_wake_clr,
        .status(chan_status), .flush_req, .kick
    );

    dma_csr_cmdptr #(.DATA_W(DATA_W), .ALIGN_B(4)) u_ptr (
        .clk, .rst_n, .ptr_wr, .wdata(reg_wdata),
        .active(chan_status[B_ACTIVE]), .ptr(cmd_ptr), .fetch_req
    );

    dma_csr_scratch #(.NUM_REGS(NUM_REGS), .FIRST(FIRST_SCR), .DATA_W(DATA_W)) u_scr (
        .clk, .rst_n, .wr(reg_wr), .idx(reg_idx), .wdata(reg_wdata), .rdata(scr_rdata)
    );

    // Read-data selection across the register window.
    always_comb begin
        if (reg_idx == IDX_W'(IDX_CTL))         reg_rdata = DATA_W'(chan_status);
        else if (reg_idx == IDX_W'(IDX_CMDPTR)) reg_rdata = cmd_ptr;
        else                                    reg_rdata = scr_rdata;
    end

    a_r9_hw_bits_not_from_sw: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chan_status[B_DEAD]) |-> $past(seq_dead));
    a_r10_kick_after_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
        kick |-> $past(ctl_wr));
endmodule

// File: tb/test_dma_chan_csr.sv
module test_dma_chan_csr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  dev_stat = '0;
    logic        seq_dead = 1'b0, seq_stop = 1'b0, seq_bt_set = 1'b0;
    logic        seq_bt_clr = 1'b0, seq_wake_clr = 1'b0;
    logic [15:0] chan_status;
    logic [31:0] cmd_ptr;
    logic        flush_req, kick, fetch_req;
    int          checks = 0, failures = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    dma_chan_csr i_dma_chan_csr (
        .clk, .rst_n, .reg_wr, .reg_idx, .reg_wdata, .reg_rdata, .dev_stat,
        .seq_dead, .seq_stop, .seq_bt_set, .seq_bt_clr, .seq_wake_clr,
        .chan_status, .cmd_ptr, .flush_req, .kick, .fetch_req
    );

    // {control word, expected status, expected kick, expected flush_req}
    localparam int NV = 8;
    localparam logic [49:0] VEC [NV] = '{
        {32'h8000_8000, 16'h8400, 1'b1, 1'b0},  // R3 R6 set RUN
        {32'h4000_4000, 16'hC000, 1'b0, 1'b0},  // R5 R6 pause
        {32'h4000_0000, 16'h8400, 1'b1, 1'b0},  // R5 R6 unpause
        {32'h1000_1000, 16'h9400, 1'b1, 1'b0},  // R4 wake while running
        {32'h0000_C000, 16'h9400, 1'b1, 1'b0},  // R2 unmasked values ignored
        {32'h8000_0000, 16'h1000, 1'b0, 1'b1},  // R3 clear RUN flushes
        {32'h1000_1000, 16'h1000, 1'b0, 1'b0},  // R4 wake ignored when stopped
        {32'h0D00_0D00, 16'h1000, 1'b0, 1'b0}   // R9 hw-only bits
    };

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Bus write; returns at the negedge after the capturing edge.
    task automatic wr(logic [2:0] idx, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] idx, output logic [31:0] d);
        reg_idx = idx;
        #1 d = reg_rdata;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        for (int i = 0; i < 8; i++) begin rd(3'(i), v); chk("R1", v, 0); end
        chk("R1", {29'd0, flush_req, kick, fetch_req}, 0);

        for (int i = 0; i < NV; i++) begin
            wr(3'd0, VEC[i][49:18]);
            chk("R10 kick", {31'd0, kick}, {31'd0, VEC[i][1]});
            chk("R3 flush_req", {31'd0, flush_req}, {31'd0, VEC[i][0]});
            rd(3'd0, v);
            chk("R2 status", v, {16'd0, VEC[i][17:2]});
        end

        // R7 flush bit visible one cycle
        wr(3'd0, 32'h2000_2000);
        rd(3'd0, v);
        chk("R7 flush bit", v, 32'h3000);
        chk("R7 flush_req", {31'd0, flush_req}, 1);
        @(negedge clk);
        rd(3'd0, v);
        chk("R7 flush cleared", v, 32'h1000);
        chk("R7 req cleared", {31'd0, flush_req}, 0);

        // R9 wake cleared by sequencer, device status shown
        @(negedge clk) seq_wake_clr = 1'b1;
        @(negedge clk) seq_wake_clr = 1'b0;
        rd(3'd0, v); chk("R9 wake_clr", v, 32'h0);
        dev_stat = 4'hA;
        rd(3'd0, v); chk("R2 dev_stat", v, 32'h000A);
        dev_stat = 4'h0;

        // R9 dead, R3 run clear removes dead
        wr(3'd0, 32'h8000_8000);
        @(negedge clk) seq_dead = 1'b1;
        @(negedge clk) seq_dead = 1'b0;
        rd(3'd0, v); chk("R9 dead", v, 32'h8800);
        wr(3'd0, 32'h8000_0000);
        rd(3'd0, v); chk("R3 dead cleared", v, 32'h0);
        chk("R3 flush_req", {31'd0, flush_req}, 1);

        // R8 guard while active
        wr(3'd0, 32'h8000_8000);
        wr(3'd1, 32'hAAAA_AAA0);
        chk("R8 no fetch", {31'd0, fetch_req}, 0);
        rd(3'd1, v); chk("R8 guarded", v, 32'h0);
        // R6 ACTIVE unchanged when write touches nothing relevant
        @(negedge clk) seq_stop = 1'b1;
        @(negedge clk) seq_stop = 1'b0;
        rd(3'd0, v); chk("R9 stop", v, 32'h8000);
        wr(3'd0, 32'h0000_0000);
        rd(3'd0, v); chk("R6 active unchanged", v, 32'h8000);
        chk("R10 no kick", {31'd0, kick}, 0);
        wr(3'd1, 32'h1234_567F);
        chk("R8 fetch", {31'd0, fetch_req}, 1);
        rd(3'd1, v); chk("R8 aligned", v, 32'h1234_5670);
        @(negedge clk);
        chk("R8 fetch one cycle", {31'd0, fetch_req}, 0);

        // R9 branch-taken bit
        @(negedge clk) seq_bt_set = 1'b1;
        @(negedge clk) seq_bt_set = 1'b0;
        rd(3'd0, v); chk("R9 bt set", v, 32'h8100);
        @(negedge clk) seq_bt_clr = 1'b1;
        @(negedge clk) seq_bt_clr = 1'b0;
        rd(3'd0, v); chk("R9 bt clr", v, 32'h8000);

        // R11 plain registers
        wr(3'd3, 32'hDEAD_BEEF);
        wr(3'd7, 32'h0F0F_0F0F);
        rd(3'd3, v); chk("R11 reg3", v, 32'hDEAD_BEEF);
        rd(3'd7, v); chk("R11 reg7", v, 32'h0F0F_0F0F);
        rd(3'd2, v); chk("R11 reg2", v, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule